// File: doc/BRIEF.md
# Playback DMA request controller

This block raises the host DMA request for an audio playback channel and keeps track of terminal count. Software programs a run enable, a mask that decides whether terminal count stops the channel, a 6-bit burst length, and a mode register that holds an I/O-transfer select, the sample format bits and a read-only terminal-count flag. While the channel runs, the playback FIFO has room and programmed I/O mode is off, the request line is raised. The host then acknowledges one transfer per clock with the active-low acknowledge. The request is released after the burst length plus one transfers.

The burst counter reloads from the burst length register on every cycle in which the acknowledge is inactive, so software never has to reprogram it. Master reset leaves that register untouched. A terminal count that arrives with an acknowledged transfer sets the status flag. Unless the mask is set, it also clears the run enable. The flag drives the playback interrupt when both interrupt enables are high, and software can hold it clear through a status register.

Top module: `pbdma_req`

## Requirements
- R1: Registers sit at reg_addr 0 (control), 1 (burst length, bits 5:0), 2 (mode) and 3 (status clear, bit 0). In control, bit 0 is run and bit 6 is the terminal-count mask. Every other control bit reads as 0. A write takes effect at the clock edge on which reg_we is high, and reg_rdata shows the addressed register combinationally.
- R2: Master reset (rst high at a clock edge) clears run, the mask, the whole mode register, the terminal-count flag and the status clear bit, and forces drq low. The burst length register keeps its value.
- R3: Each request yields exactly burst length + 1 transfers. A transfer is a clock edge at which dack_n is 0 while drq is 1. drq is low after the edge of the last transfer.
- R4: The burst counter reloads the full burst length at every edge where dack_n is 1. After a pause in acknowledge, the burst restarts with its full count.
- R5: drq rises only at an edge where run is 1, mode bit 4 (I/O mode) is 0, fifo_room is 1 and dack_n is 1. drq falls at the edge after run is cleared or I/O mode is set.
- R6: A terminal count is tc high at an edge where dack_n is 0 and I/O mode is off. It clears run when the mask is 0 and leaves run set when the mask is 1. A control write at the same edge takes priority.
- R7: A terminal count sets the flag at mode bit 5. Writes to mode bit 5 have no effect, and mode bits 7:6 read as 0.
- R8: Writing status bit 0 = 1 clears the flag and holds it clear against later terminal counts. Writing status bit 0 = 0 releases the hold.
- R9: While I/O mode is set, drq stays low and tc affects neither the flag nor run.
- R10: play_irq is high exactly when the flag is set and both irq_en_fifo and irq_en_play are 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high master reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address for read and write |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Read data of the addressed register |
| dack_n | input | 1 | DMA acknowledge, active low |
| tc | input | 1 | Terminal count strobe from the host |
| fifo_room | input | 1 | Playback FIFO has room for a full burst |
| irq_en_fifo | input | 1 | FIFO interrupt enable |
| irq_en_play | input | 1 | Playback interrupt enable |
| drq | output | 1 | DMA request |
| play_irq | output | 1 | Playback interrupt |

## Verification
Register writes, run clearing and flag changes all land on the edge that samples the stimulus, and drq follows its conditions one edge later. reg_rdata and play_irq follow their registers with no further delay. The bench changes inputs and samples outputs on the falling edge, so every expected value is taken half a cycle after the edge that must produce it. Burst lengths are scored by a monitor that acts as the host: it counts acknowledged edges until drq falls and compares the count with the value the driver queued.

// File: rtl/pbdma_pkg.sv
package pbdma_pkg;

    localparam int REG_W  = 8;
    localparam int ADDR_W = 2;

    typedef enum logic [ADDR_W-1:0] {
        ADR_CTRL = 2'd0,
        ADR_BLEN = 2'd1,
        ADR_MODE = 2'd2,
        ADR_STAT = 2'd3
    } reg_addr_e;

    localparam int CTRL_RUN_BIT  = 0;
    localparam int CTRL_MASK_BIT = 6;
    localparam int MODE_FLAG_BIT = 5;
    localparam int STAT_CLR_BIT  = 0;

    typedef enum logic [1:0] {
        FMT_LIN8  = 2'd0,
        FMT_LIN16 = 2'd1,
        FMT_MU8   = 2'd2,
        FMT_A8    = 2'd3
    } fmt_e;

    typedef struct packed {
        logic mask;
        logic run;
    } ctrl_t;

    typedef struct packed {
        logic iox;
        logic usgn;
        logic wide;
        fmt_e fmt;
    } mode_t;

    localparam int MODE_W = $bits(mode_t);

    function automatic logic [REG_W-1:0] ctrl_to_byte(input ctrl_t c);
        logic [REG_W-1:0] b;
        b = '0;
        b[CTRL_RUN_BIT]  = c.run;
        b[CTRL_MASK_BIT] = c.mask;
        return b;
    endfunction

    function automatic ctrl_t byte_to_ctrl(input logic [REG_W-1:0] b);
        ctrl_t c;
        c.run  = b[CTRL_RUN_BIT];
        c.mask = b[CTRL_MASK_BIT];
        return c;
    endfunction

    function automatic logic [REG_W-1:0] mode_to_byte(input mode_t m, input logic flag);
        logic [REG_W-1:0] b;
        b = '0;
        b[MODE_W-1:0]    = m;
        b[MODE_FLAG_BIT] = flag;
        return b;
    endfunction

    function automatic mode_t byte_to_mode(input logic [REG_W-1:0] b);
        return mode_t'(b[MODE_W-1:0]);
    endfunction

endpackage

// File: rtl/pbdma_regs.sv
module pbdma_regs
    import pbdma_pkg::*;
#(
    parameter int BURST_W = 6
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               we,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [REG_W-1:0]   wdata,
    input  logic               tc_evt,
    input  logic               flag,
    output logic [REG_W-1:0]   rdata,
    output logic               run,
    output logic               iox,
    output logic [BURST_W-1:0] blen,
    output logic               clr_set,
    output logic               clr_hold
);

    localparam int PAD_W = REG_W - BURST_W;

    reg_addr_e addr_e;
    ctrl_t     ctrl_q;
    mode_t     mode_q;
    logic      wr_ctrl;
    logic      wr_blen;
    logic      wr_mode;
    logic      wr_stat;

    assign addr_e  = reg_addr_e'(addr);
    assign wr_ctrl = we && (addr_e == ADR_CTRL);
    assign wr_blen = we && (addr_e == ADR_BLEN);
    assign wr_mode = we && (addr_e == ADR_MODE);
    assign wr_stat = we && (addr_e == ADR_STAT);
    assign clr_set = wr_stat && wdata[STAT_CLR_BIT];

    // control: a write wins over a terminal-count clear in the same cycle
    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
        end else if (wr_ctrl) begin
            ctrl_q <= byte_to_ctrl(wdata);
        end else if (tc_evt && !ctrl_q.mask) begin
            ctrl_q.run <= 1'b0;
        end
    end

    // burst length survives master reset; only a write changes it
    always_ff @(posedge clk) begin
        if (wr_blen) begin
            blen <= wdata[BURST_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= '0;
        end else if (wr_mode) begin
            mode_q <= byte_to_mode(wdata);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            clr_hold <= 1'b0;
        end else if (wr_stat) begin
            clr_hold <= wdata[STAT_CLR_BIT];
        end
    end

    always_comb begin
        unique case (addr_e)
            ADR_CTRL: rdata = ctrl_to_byte(ctrl_q);
            ADR_BLEN: rdata = {{PAD_W{1'b0}}, blen};
            ADR_MODE: rdata = mode_to_byte(mode_q, flag);
            ADR_STAT: rdata = {{(REG_W-1){1'b0}}, clr_hold};
            default:  rdata = '0;
        endcase
    end

    assign run = ctrl_q.run;
    assign iox = mode_q.iox;

    // R6
    tc_clears_run_chk: assert property (@(posedge clk) disable iff (rst)
        (tc_evt && !ctrl_q.mask && !wr_ctrl) |=> !ctrl_q.run);

    // R6
    tc_masked_keeps_run_chk: assert property (@(posedge clk) disable iff (rst)
        (tc_evt && ctrl_q.mask && ctrl_q.run && !wr_ctrl) |=> ctrl_q.run);

    // R2
    reset_clears_regs_chk: assert property (@(posedge clk)
        rst |=> (ctrl_q == '0 && mode_q == '0 && !clr_hold));

endmodule

// File: rtl/pbdma_burst.sv
module pbdma_burst #(
    parameter int BURST_W = 6
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               dack_n,
    input  logic [BURST_W-1:0] blen,
    input  logic               run,
    input  logic               iox,
    input  logic               fifo_room,
    output logic               drq
);

    logic [BURST_W-1:0] cnt;
    logic               xfer;
    logic               cnt_zero;

    assign xfer     = !dack_n;
    assign cnt_zero = (cnt == '0);

    // preset while acknowledge is inactive, count down on each acknowledged edge
    always_ff @(posedge clk) begin
        if (rst || dack_n) begin
            cnt <= blen;
        end else if (!cnt_zero) begin
            cnt <= cnt - BURST_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            drq <= 1'b0;
        end else if (!run || iox) begin
            drq <= 1'b0;
        end else if (drq && xfer && cnt_zero) begin
            drq <= 1'b0;
        end else if (!drq && fifo_room && dack_n) begin
            drq <= 1'b1;
        end
    end

    // R4
    preset_on_idle_chk: assert property (@(posedge clk) disable iff (rst)
        dack_n |=> (cnt == $past(blen)));

    // R3
    countdown_chk: assert property (@(posedge clk) disable iff (rst)
        (xfer && !cnt_zero) |=> (cnt == $past(cnt) - BURST_W'(1)));

    // R5
    drq_rise_cond_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(drq) |-> $past(run && !iox && fifo_room && dack_n));

    // R3
    drq_fall_cond_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(drq) |-> $past(!run || iox || (xfer && cnt_zero)));

endmodule

// File: rtl/pbdma_tcflag.sv
module pbdma_tcflag (
    input  logic clk,
    input  logic rst,
    input  logic tc_evt,
    input  logic clr_set,
    input  logic clr_hold,
    input  logic irq_en_fifo,
    input  logic irq_en_play,
    output logic flag,
    output logic irq
);

    always_ff @(posedge clk) begin
        if (rst || clr_set || clr_hold) begin
            flag <= 1'b0;
        end else if (tc_evt) begin
            flag <= 1'b1;
        end
    end

    assign irq = flag && irq_en_fifo && irq_en_play;

    // R8
    hold_keeps_clear_chk: assert property (@(posedge clk) disable iff (rst)
        clr_hold |-> !flag);

    // R7
    tc_sets_flag_chk: assert property (@(posedge clk) disable iff (rst)
        (tc_evt && !clr_set && !clr_hold) |=> flag);

    // R10
    irq_needs_flag_chk: assert property (@(posedge clk) disable iff (rst)
        irq |-> flag);

endmodule

// File: rtl/pbdma_req.sv
module pbdma_req
    import pbdma_pkg::*;
#(
    parameter int BURST_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             reg_we,
    input  logic [1:0]       reg_addr,
    input  logic [7:0]       reg_wdata,
    output logic [7:0]       reg_rdata,
    input  logic             dack_n,
    input  logic             tc,
    input  logic             fifo_room,
    input  logic             irq_en_fifo,
    input  logic             irq_en_play,
    output logic             drq,
    output logic             play_irq
);

    logic               run;
    logic               iox;
    logic [BURST_W-1:0] blen;
    logic               clr_set;
    logic               clr_hold;
    logic               flag;
    logic               tc_evt;

    assign tc_evt = tc && !dack_n && !iox;

    pbdma_regs #(.BURST_W(BURST_W)) regs_i (
        .clk      (clk),
        .rst      (rst),
        .we       (reg_we),
        .addr     (reg_addr),
        .wdata    (reg_wdata),
        .tc_evt   (tc_evt),
        .flag     (flag),
        .rdata    (reg_rdata),
        .run      (run),
        .iox      (iox),
        .blen     (blen),
        .clr_set  (clr_set),
        .clr_hold (clr_hold)
    );

    pbdma_burst #(.BURST_W(BURST_W)) burst_i (
        .clk       (clk),
        .rst       (rst),
        .dack_n    (dack_n),
        .blen      (blen),
        .run       (run),
        .iox       (iox),
        .fifo_room (fifo_room),
        .drq       (drq)
    );

    pbdma_tcflag tcflag_i (
        .clk         (clk),
        .rst         (rst),
        .tc_evt      (tc_evt),
        .clr_set     (clr_set),
        .clr_hold    (clr_hold),
        .irq_en_fifo (irq_en_fifo),
        .irq_en_play (irq_en_play),
        .flag        (flag),
        .irq         (play_irq)
    );

    // R9
    iox_blocks_drq_chk: assert property (@(posedge clk) disable iff (rst)
        iox |=> !drq);

endmodule

// File: tb/pbdma_req_tb_top.sv
module pbdma_req_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 100000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       reg_we = 1'b0;
    logic [1:0] reg_addr = 2'd0;
    logic [7:0] reg_wdata = 8'd0;
    logic [7:0] reg_rdata;
    logic       dack_n;
    logic       tc = 1'b0;
    logic       fifo_room = 1'b0;
    logic       irq_en_fifo = 1'b0;
    logic       irq_en_play = 1'b0;
    logic       drq;
    logic       play_irq;

    logic       host_en = 1'b0;
    logic       host_dack = 1'b1;
    logic       dack_man = 1'b1;

    int checks = 0;
    int errors = 0;
    int exp_q[$];
    int xfer_cnt = 0;
    logic drq_prev = 1'b0;
    logic [7:0] rv;

    assign dack_n = host_en ? host_dack : dack_man;

    always #(CLK_PERIOD/2) clk = ~clk;

    pbdma_req dut_i (
        .clk         (clk),
        .rst         (rst),
        .reg_we      (reg_we),
        .reg_addr    (reg_addr),
        .reg_wdata   (reg_wdata),
        .reg_rdata   (reg_rdata),
        .dack_n      (dack_n),
        .tc          (tc),
        .fifo_room   (fifo_room),
        .irq_en_fifo (irq_en_fifo),
        .irq_en_play (irq_en_play),
        .drq         (drq),
        .play_irq    (play_irq)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    // host model and scoreboard monitor
    always @(negedge clk) begin
        if (host_en) begin
            if (!dack_n) xfer_cnt++;
            if (drq_prev && !drq && xfer_cnt > 0) begin
                if (exp_q.size() > 0) begin
                    chk("R3 transfers per burst", xfer_cnt, exp_q.pop_front());
                end
                xfer_cnt = 0;
            end
            host_dack = !drq;
        end else begin
            xfer_cnt  = 0;
            host_dack = 1'b1;
        end
        drq_prev = drq;
    end

    // all tasks start and end just after a falling edge
    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic ack_low(input int n, input logic tcv);
        dack_man = 1'b0; tc = tcv;
        repeat (n) @(negedge clk);
        tc = 1'b0;
    endtask

    task automatic ack_high(input int n);
        dack_man = 1'b1;
        repeat (n) @(negedge clk);
    endtask

    task automatic run_bursts(input logic [5:0] len, input int n);
        wr(2'd1, {2'b00, len});
        for (int i = 0; i < n; i++) exp_q.push_back(int'(len) + 1);
        host_en = 1'b1;
        wr(2'd0, 8'h01);
        wait (exp_q.size() == 0);
        @(negedge clk);
        wr(2'd0, 8'h00);
        idle(2);
        host_en = 1'b0;
        idle(2);
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        idle(3);
        rst = 1'b0;
        idle(1);

        // R2 reset state
        rd(2'd0, rv); chk("R2 control after reset", rv, 8'h00);
        rd(2'd2, rv); chk("R2 mode after reset", rv, 8'h00);
        chk("R2 drq after reset", drq, 0);

        // R1 control layout, reserved bits read zero
        wr(2'd0, 8'hFE);
        rd(2'd0, rv); chk("R1 control reserved bits", rv, 8'h40);
        wr(2'd0, 8'h00);
        wr(2'd1, 8'hFF);
        rd(2'd1, rv); chk("R1 burst length width", rv, 8'h3F);

        // R7 flag bit is read only, upper bits zero
        wr(2'd2, 8'hEF);
        rd(2'd2, rv); chk("R7 mode bit5 read only", rv, 8'h0F);
        wr(2'd2, 8'h00);

        // R3 burst lengths via scoreboard
        fifo_room = 1'b1;
        run_bursts(6'd3, 3);
        run_bursts(6'd0, 3);
        run_bursts(6'd63, 2);
        chk("R3 drq low after stop", drq, 0);

        // R5 no request without FIFO room
        fifo_room = 1'b0;
        wr(2'd1, 8'h03);
        wr(2'd0, 8'h01);
        idle(4);
        chk("R5 drq held without room", drq, 0);
        fifo_room = 1'b1;
        idle(1);
        chk("R5 drq rises with room", drq, 1);

        // R4 reload during a pause in acknowledge
        ack_low(2, 1'b0);
        ack_high(1);
        ack_low(3, 1'b0);
        chk("R4 burst restarted after reload", drq, 1);
        ack_low(1, 1'b0);
        chk("R4 drq drops after full count", drq, 0);
        ack_high(2);

        // R6 terminal count clears run when unmasked
        irq_en_fifo = 1'b1; irq_en_play = 1'b1;
        chk("R5 drq before tc", drq, 1);
        ack_low(1, 1'b1);
        ack_high(0);
        rd(2'd0, rv); chk("R6 run cleared by tc", rv, 8'h00);
        rd(2'd2, rv); chk("R7 flag set by tc", rv, 8'h20);
        chk("R10 irq with both enables", play_irq, 1);
        irq_en_play = 1'b0; #1;
        chk("R10 irq gated by enable", play_irq, 0);
        irq_en_play = 1'b1;
        idle(1);
        chk("R5 drq drops after run cleared", drq, 0);

        // R8 status hold clear
        wr(2'd3, 8'h01);
        rd(2'd2, rv); chk("R8 flag cleared by status", rv, 8'h00);
        chk("R10 irq low with flag clear", play_irq, 0);
        ack_low(1, 1'b1);
        ack_high(0);
        rd(2'd2, rv); chk("R8 flag held clear", rv, 8'h00);
        wr(2'd3, 8'h00);
        ack_low(1, 1'b1);
        ack_high(0);
        rd(2'd2, rv); chk("R8 flag sets after release", rv, 8'h20);

        // R6 masked terminal count keeps run
        wr(2'd0, 8'h41);
        ack_low(1, 1'b1);
        ack_high(0);
        rd(2'd0, rv); chk("R6 run kept when masked", rv, 8'h41);

        // R6 control write wins over tc in same cycle
        wr(2'd0, 8'h00);
        reg_we = 1'b1; reg_addr = 2'd0; reg_wdata = 8'h01;
        dack_man = 1'b0; tc = 1'b1;
        @(negedge clk);
        reg_we = 1'b0; tc = 1'b0; dack_man = 1'b1;
        rd(2'd0, rv); chk("R6 write wins over tc", rv, 8'h01);

        // R9 I/O mode disables request and terminal count
        wr(2'd3, 8'h01);
        wr(2'd3, 8'h00);
        wr(2'd2, 8'h10);
        idle(3);
        chk("R9 drq off in io mode", drq, 0);
        ack_low(1, 1'b1);
        ack_high(0);
        rd(2'd2, rv); chk("R9 tc ignored for flag", rv, 8'h10);
        rd(2'd0, rv); chk("R9 tc ignored for run", rv, 8'h01);

        // R2 reset keeps burst length, clears the rest
        wr(2'd1, 8'h05);
        wr(2'd0, 8'h41);
        wr(2'd3, 8'h01);
        rst = 1'b1;
        idle(2);
        rst = 1'b0;
        rd(2'd1, rv); chk("R2 burst length kept", rv, 8'h05);
        rd(2'd0, rv); chk("R2 control cleared", rv, 8'h00);
        rd(2'd2, rv); chk("R2 mode cleared", rv, 8'h00);
        rd(2'd3, rv); chk("R2 status cleared", rv, 8'h00);
        chk("R2 drq low", drq, 0);

        idle(2);
        finish_run();
    end

endmodule